// File: doc/BRIEF.md
# RAM-Backed Tapped Delay Line

This block is a delay line with several evenly spaced outputs. A single memory holds the samples in place of a long chain of flip-flops. Each enabled clock takes one `DATA_W`-bit sample. The block presents `NUM_TAPS` outputs. Each output lags the one before it by `TAP_GAP` samples, so the full span of the line is `TAP_GAP × NUM_TAPS` samples.

The memory has `TAP_GAP` words, and each word is `DATA_W × NUM_TAPS` bits wide. A circular address pointer selects one word per enabled cycle. On that single clock edge the block captures the old word as the new tap outputs. It then writes the word back, moved up by one tap slot, with the incoming sample placed in the lowest slot. Typical users are filter datapaths and correlators, which need many long, equally spaced delays.

Top module: `ramtap_line`

## Requirements
- R1: While `rst_ni` is low, the pointer returns to word 0 and `taps_o` is all zeros. Stored memory words are not cleared by reset.
- R2: The pointer visits words 0, 1, … `TAP_GAP-1` and then wraps back to 0. It moves by one word on each clock edge where `en_i` is high.
- R3: On a clock edge where `en_i` is low, the pointer holds, no memory word is written, and `taps_o` keeps its value. Later outputs match a sample stream in which that cycle did not happen.
- R4: Tap k (1-based) sits at bits `[k*DATA_W-1 : (k-1)*DATA_W]` of `taps_o`. After an enabled edge, tap k carries the sample that entered `k*TAP_GAP` enabled edges before the sample taken at that edge. A tap is only defined once that many samples have entered since reset.
- R5: The word written back on an enabled edge equals the word read at that edge, moved up by one tap slot, with the new sample in the lowest slot. As a result, tap k+1 repeats tap k exactly `TAP_GAP` enabled cycles later.
- R6: `taps_o` is registered. It changes only on an enabled clock edge, and it reflects that edge's read at once, with no further delay.
- R7: The parameters must meet four limits: `DATA_W*TAP_GAP*NUM_TAPS <= 4608`, `DATA_W*NUM_TAPS <= 36`, `TAP_GAP >= 2` and `NUM_TAPS >= 1`. If any limit is broken, elaboration stops with an error. The width of `taps_o` is `DATA_W*NUM_TAPS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample enable: a shift step happens on this edge |
| din_i | input | DATA_W | Incoming sample |
| taps_o | output | DATA_W*NUM_TAPS | Tap outputs, tap 1 in the lowest slot |

## Verification
The assertions check the following on every cycle:
- the pointer stays in range, steps and wraps correctly, and holds while the enable is low;
- the outputs freeze on disabled edges and are zero during reset;
- each written word is the read word moved up one slot, with the new sample added at the bottom.

Only the bench's scenarios can show that the assembled delays come out right: that every tap equals the sample from exactly `k*TAP_GAP` enabled cycles earlier. This holds across many pointer wraps, irregular enable gaps, and a reset in the middle of a run whose stale memory must not leak into defined taps.

// File: rtl/ramtap_pkg.sv
package ramtap_pkg;
  localparam int unsigned BLOCK_BITS    = 4608;
  localparam int unsigned WORD_BITS_MAX = 36;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ramtap_ptr.sv
module ramtap_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = ramtap_pkg::ptr_width(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R2
  p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);
  p_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
  // R3
  p_ptr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/ramtap_store.sv
module ramtap_store #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_TAPS = 4,
  localparam int unsigned PTR_W  = ramtap_pkg::ptr_width(DEPTH),
  localparam int unsigned WORD_W = DATA_W * NUM_TAPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [WORD_W-1:0] rd_q_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_q;

  assign rd_word = mem[addr_i];

  // Move every slot up by one, new sample into slot 0
  generate
    if (NUM_TAPS > 1) begin : g_shift
      assign wr_word = {rd_word[WORD_W-DATA_W-1:0], din_i};
    end else begin : g_single
      assign wr_word = din_i;
    end
  endgenerate

  // Read-first storage: old word captured, shifted word written, same edge
  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wr_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (we_i) rd_q <= rd_word;
  end

  assign rd_q_o = rd_q;

  // R5: stored word = captured word moved up one slot plus the new sample
  p_new_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(addr_i)][DATA_W-1:0] == $past(din_i));
  generate
    if (NUM_TAPS > 1) begin : g_chk
      p_shift_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> mem[$past(addr_i)][WORD_W-1:DATA_W] == rd_q[WORD_W-DATA_W-1:0]);
    end
  endgenerate
endmodule

// File: rtl/ramtap_line.sv
module ramtap_line #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TAP_GAP  = 16,
  parameter int unsigned NUM_TAPS = 4,
  localparam int unsigned WORD_W = DATA_W * NUM_TAPS,
  localparam int unsigned PTR_W  = ramtap_pkg::ptr_width(TAP_GAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [WORD_W-1:0] taps_o
);
  // R7: configuration limits
  generate
    if (DATA_W * TAP_GAP * NUM_TAPS > ramtap_pkg::BLOCK_BITS) begin : g_bad_bits
      $error("ramtap_line: total storage exceeds block capacity");
    end
    if (WORD_W > ramtap_pkg::WORD_BITS_MAX) begin : g_bad_word
      $error("ramtap_line: word width exceeds widest memory word");
    end
    if (TAP_GAP < 2) begin : g_bad_gap
      $error("ramtap_line: tap spacing must be at least 2");
    end
    if (NUM_TAPS < 1 || DATA_W < 1) begin : g_bad_count
      $error("ramtap_line: need at least one tap of nonzero width");
    end
  endgenerate

  logic [PTR_W-1:0] ptr;

  ramtap_ptr #(.DEPTH(TAP_GAP)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (en_i),
    .ptr_o (ptr)
  );

  ramtap_store #(
    .DEPTH   (TAP_GAP),
    .DATA_W  (DATA_W),
    .NUM_TAPS(NUM_TAPS)
  ) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (en_i),
    .addr_i(ptr),
    .din_i (din_i),
    .rd_q_o(taps_o)
  );

  // R1
  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> taps_o == '0);
  // R3, R6
  p_taps_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(taps_o));
endmodule

// File: tb/sim_ramtap_line.sv
`timescale 1ns/1ps
module sim_ramtap_line;
  localparam int unsigned W = 8;
  localparam int unsigned M = 5;
  localparam int unsigned N = 4;
  localparam int unsigned HMAX = 8192;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] din_i = '0;
  logic [W*N-1:0] taps_o;

  int checks = 0;
  int failures = 0;
  int cnt = 0;
  logic [W-1:0] hist [HMAX];
  logic [W*N-1:0] prev_taps;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ramtap_line #(.DATA_W(W), .TAP_GAP(M), .NUM_TAPS(N)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .din_i(din_i), .taps_o(taps_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after negedge, sample 2 ns after the posedge
  task automatic step(input logic en, input logic [W-1:0] d);
    @(negedge clk_i);
    en_i = en;
    din_i = d;
    prev_taps = taps_o;
    @(posedge clk_i);
    #2;
    if (en) begin
      hist[cnt] = d;
      cnt++;
      for (int k = 1; k <= int'(N); k++) begin
        int idx = cnt - 1 - k * int'(M);
        if (idx >= 0)
          chk($sformatf("R4 tap%0d", k), 64'(taps_o[k*W-1 -: W]), 64'(hist[idx]));
      end
    end else begin
      chk("R3 hold", 64'(taps_o), 64'(prev_taps));
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    en_i = 1'b1;
    din_i = 8'hA5;
    rst_ni = 1'b0;
    @(posedge clk_i);
    #2;
    chk("R1 taps zero in reset", 64'(taps_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    en_i = 1'b0;
    cnt = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    chk("R7 tap port width", 64'($bits(taps_o)), 64'(W*N));
    do_reset();
    // R2 R4 R5 R6: counting pattern, every edge enabled, many wraps
    for (int i = 0; i < 300; i++) step(1'b1, W'(i * 7 + 3));
    // R3: disabled edges with changing data leave no trace
    for (int i = 0; i < 200; i++) step(i % 3 == 0, W'($urandom));
    // random data, random gaps
    for (int i = 0; i < 2000; i++) step(($urandom % 4) != 0, W'($urandom));
    // R1: mid-run reset, then refill over stale memory
    do_reset();
    for (int i = 0; i < 400; i++) step(($urandom % 2) == 0, W'($urandom));
    // R2: long idle run, then resume
    for (int i = 0; i < 50; i++) step(1'b0, W'(i));
    for (int i = 0; i < 200; i++) step(1'b1, W'(255 - i));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule